// File: doc/BRIEF.md
# Stereo PCM serial output port

This block shifts a stereo pair of 24-bit PCM samples out on one serial data line. It follows a bit clock and a frame clock that arrive as ordinary inputs sampled in the block's own clock domain. They come from the chip's timing controller in master mode, or from an external device in slave mode. Two configuration pins choose the framing and the word length. Framing is either left-justified or I2S. The word is either 24 bits in a 32-clock channel slot, or 16 bits in a 16-clock slot.

A producer presents a sample pair with a one-cycle valid strobe, and the port holds it as pending. The pending pair becomes the active pair at the start of the next left-channel slot. If no new pair has arrived by then, the active pair is sent again. Every change of the frame clock restarts the slot bit counter, so the port always re-aligns to the frame clock it is given. Configuration pins are expected to change only while the block is held in reset.

Top module: `pcm_serial_tx`

## Requirements
- R1: While reset is held and after it is released, `sdo` is 0. No data bit is sent before the first frame clock change into the left phase.
- R2: With `fmt[0]`=1 (left-justified), the left channel occupies the phase with `lrck` high. The MSB is driven on the same bit clock falling edge at which `lrck` changes.
- R3: With `fmt[0]`=0 (I2S), the left channel occupies the phase with `lrck` low. The MSB is driven one bit clock later than in left-justified framing.
- R4: With `fmt[1]`=0 (long word), each channel slot is 32 bit clocks: 24 sample bits MSB first, and every remaining clock of the slot carries 0.
- R5: With `fmt[1]`=1 in slave mode, each slot is 16 bit clocks carrying sample bits 23 down to 8 (the lower 8 bits are dropped). In I2S framing the first clock of a slot carries bit 8 of the channel sent just before.
- R6: With `master`=1, `fmt[1]` has no effect, and the port uses the long 24-bit/32-clock word format.
- R7: `sdo` changes only in response to a falling edge of `bck`.
- R8: A pair strobed with `in_valid` is sent starting at the next left slot. A pair strobed during a frame leaves that frame's right channel unchanged. With no new strobe, the previous pair is sent again.
- R9: Any change of `lrck` restarts the slot counter, so a shortened slot is followed by a correctly aligned next slot. Bit clocks past the end of a slot give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; `bck` and `lrck` are sampled with it |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe marking a new sample pair |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| fmt | input | 2 | bit 0: 1 left-justified, 0 I2S; bit 1: 1 short 16-bit word |
| master | input | 1 | 1 when the clocks come from the internal timing controller |
| bck | input | 1 | Bit clock |
| lrck | input | 1 | Frame clock |
| sdo | output | 1 | Serial data, updated on bit clock falling edges |

## Verification
The assertions assume that `bck` and `lrck` are much slower than `clk` and change only at `clk` edges. They also assume that `lrck` changes together with a falling `bck`, and that `fmt` and `master` stay constant outside reset. The bench holds every bit clock phase for four block clocks and moves `lrck` only at the start of a low bit clock phase. It changes the configuration pins only inside a reset sequence, and it issues valid strobes only between channel slots.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic {
    FRAME_I2S = 1'b0,
    FRAME_LJ  = 1'b1
  } frame_e;
endpackage

// File: rtl/pcm_tx_edge.sv
module pcm_tx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bck,
  input  logic lrck,
  output logic bck_fall,
  output logic lrck_s
);
  logic bck_q, bck_q2, lrck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_q  <= 1'b1;
      bck_q2 <= 1'b1;
      lrck_q <= 1'b0;
    end else begin
      bck_q  <= bck;
      bck_q2 <= bck_q;
      lrck_q <= lrck;
    end
  end

  assign bck_fall = bck_q2 & ~bck_q;
  assign lrck_s   = lrck_q;
endmodule

// File: rtl/pcm_tx_counter.sv
module pcm_tx_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bck_fall,
  input  logic             lrck_s,
  input  logic             lrck_rst_level,
  output logic             lrck_chg,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             lrck_last;

  assign lrck_chg = lrck_s != lrck_last;
  assign cnt_nxt  = lrck_chg ? '0 : ((cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= CNT_MAX;
      lrck_last <= lrck_rst_level;
    end else if (bck_fall) begin
      cnt_q     <= cnt_nxt;
      lrck_last <= lrck_s;
    end
  end

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (bck_fall && lrck_chg) |=> (cnt_q == '0));

  a_r9_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (bck_fall && !lrck_chg && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bck_fall |=> $stable(cnt_q));
endmodule

// File: rtl/pcm_tx_hold.sv
module pcm_tx_hold #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                load,
  output logic [SAMPLE_W-1:0] next_left,
  output logic [SAMPLE_W-1:0] act_left,
  output logic [SAMPLE_W-1:0] act_right
);
  logic [SAMPLE_W-1:0] pend_l, pend_r;
  logic                pend_full;

  assign next_left = pend_full ? pend_l : act_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_l    <= '0;
      pend_r    <= '0;
      pend_full <= 1'b0;
      act_left  <= '0;
      act_right <= '0;
    end else begin
      if (load && pend_full) begin
        act_left  <= pend_l;
        act_right <= pend_r;
      end
      if (in_valid) begin
        pend_l    <= in_left;
        pend_r    <= in_right;
        pend_full <= 1'b1;
      end else if (load) begin
        pend_full <= 1'b0;
      end
    end
  end

  a_r8_pending: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> pend_full);

  a_r8_keep_active: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_left) && $stable(act_right)));
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int SHORT_W    = 16,
  parameter int LONG_SLOT  = 32,
  parameter int SHORT_SLOT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic [1:0]          fmt,
  input  logic                master,
  input  logic                bck,
  input  logic                lrck,
  output logic                sdo
);
  localparam int CNT_W = $clog2(2 * LONG_SLOT);
  localparam logic [CNT_W-1:0] SLOT_L = CNT_W'(LONG_SLOT);
  localparam logic [CNT_W-1:0] SLOT_S = CNT_W'(SHORT_SLOT);
  localparam logic [CNT_W-1:0] WLEN_L = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] WLEN_S = CNT_W'(SHORT_W);
  localparam int CARRY_IDX = SAMPLE_W - SHORT_W;

  // Bit idx (0 = MSB) of a word, zero past the word length.
  function automatic logic word_bit(input logic [SAMPLE_W-1:0] w,
                                    input logic [CNT_W-1:0] idx,
                                    input logic [CNT_W-1:0] wlen);
    logic [SAMPLE_W-1:0] shifted;
    shifted = w << idx;
    return (idx < wlen) ? shifted[SAMPLE_W-1] : 1'b0;
  endfunction

  frame_e              fmode;
  logic                word16, left_now, load, bit_out;
  logic                bck_fall, lrck_s, lrck_chg;
  logic [CNT_W-1:0]    cnt_nxt, slot_len, wlen;
  logic [SAMPLE_W-1:0] next_left, act_left, act_right, cur_word, prev_word;

  assign fmode    = frame_e'(fmt[0]);
  assign word16   = fmt[1] & ~master;
  assign slot_len = word16 ? SLOT_S : SLOT_L;
  assign wlen     = word16 ? WLEN_S : WLEN_L;
  assign left_now = (fmode == FRAME_LJ) ? lrck_s : ~lrck_s;
  assign load     = bck_fall & lrck_chg & left_now;

  pcm_tx_edge i_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bck      (bck),
    .lrck     (lrck),
    .bck_fall (bck_fall),
    .lrck_s   (lrck_s)
  );

  pcm_tx_counter #(.CNT_W(CNT_W)) i_counter (
    .clk            (clk),
    .rst_n          (rst_n),
    .bck_fall       (bck_fall),
    .lrck_s         (lrck_s),
    .lrck_rst_level (~fmt[0]),
    .lrck_chg       (lrck_chg),
    .cnt_nxt        (cnt_nxt)
  );

  pcm_tx_hold #(.SAMPLE_W(SAMPLE_W)) i_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .load      (load),
    .next_left (next_left),
    .act_left  (act_left),
    .act_right (act_right)
  );

  assign cur_word  = left_now ? next_left : act_right;
  assign prev_word = left_now ? act_right : act_left;

  always_comb begin
    if (cnt_nxt >= slot_len)
      bit_out = 1'b0;
    else if (fmode == FRAME_LJ)
      bit_out = word_bit(cur_word, cnt_nxt, wlen);
    else if (cnt_nxt == '0)
      bit_out = word16 ? prev_word[CARRY_IDX] : 1'b0;
    else
      bit_out = word_bit(cur_word, cnt_nxt - 1'b1, wlen);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sdo <= 1'b0;
    else if (bck_fall)
      sdo <= bit_out;
  end

  a_r7_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !bck_fall |=> $stable(sdo));

  a_r4_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (bck_fall && !word16 && cnt_nxt > WLEN_L) |=> !sdo);

  a_r9_past_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (bck_fall && cnt_nxt >= slot_len) |=> !sdo);

  a_r6_master_long: assert property (@(posedge clk) disable iff (!rst_n)
    (master && bck_fall && cnt_nxt >= SLOT_S && cnt_nxt <= WLEN_L &&
     fmode == FRAME_LJ && cnt_nxt < SLOT_L) |=> (sdo == $past(bit_out)));
endmodule

// File: tb/test_pcm_serial_tx.sv
module test_pcm_serial_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic [1:0]  fmt = 2'b01;
  logic        master = 1'b1;
  logic        bck = 1'b1;
  logic        lrck = 1'b0;
  logic        sdo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] m_act_l, m_act_r, m_pend_l, m_pend_r, m_prev;
  bit          m_pend;

  always #10 clk = ~clk;

  pcm_serial_tx i_pcm_serial_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .fmt(fmt), .master(master), .bck(bck),
    .lrck(lrck), .sdo(sdo)
  );

  function automatic logic exp_bit(logic [23:0] w, logic [23:0] prev, int i,
                                   bit lj, bit w16);
    int j, wl;
    wl = w16 ? 16 : 24;
    if (lj) j = i;
    else if (i == 0) return w16 ? prev[8] : 1'b0;
    else j = i - 1;
    return (j < wl) ? w[23 - j] : 1'b0;
  endfunction

  task automatic do_reset(input logic [1:0] f, input logic m);
    @(negedge clk);
    rst_n = 1'b0; fmt = f; master = m; bck = 1'b1;
    lrck = f[0] ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    m_act_l = '0; m_act_r = '0; m_prev = '0; m_pend = 1'b0;
  endtask

  task automatic strobe(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    @(negedge clk);
    in_valid = 1'b0;
    m_pend = 1'b1; m_pend_l = l; m_pend_r = r;
  endtask

  task automatic bit_cycle(input logic lv, output logic got);
    @(negedge clk);
    bck = 1'b0; lrck = lv;
    repeat (4) @(negedge clk);
    got = sdo;
    bck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic half(input bit is_left, input int n, input string tag);
    bit lj, w16;
    logic [23:0] word;
    logic [63:0] got, expv;
    logic b;
    lj  = fmt[0];
    w16 = fmt[1] & ~master;
    if (is_left && m_pend) begin
      m_act_l = m_pend_l; m_act_r = m_pend_r; m_pend = 1'b0;
    end
    word = is_left ? m_act_l : m_act_r;
    got = '0; expv = '0;
    for (int i = 0; i < n; i++) begin
      bit_cycle(lj ? is_left : !is_left, b);
      got[i] = b;
      expv[i] = exp_bit(word, m_prev, i, lj, w16);
    end
    m_prev = word;
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s %s slot: actual %h expected %h", tag,
               is_left ? "left" : "right", got, expv);
    end
  endtask

  task automatic frame(input string tag);
    int s;
    s = (fmt[1] & ~master) ? 16 : 32;
    half(1'b1, s, tag);
    half(1'b0, s, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (sdo !== 1'b0) begin errors++; $display("FAIL R1 reset: actual %b expected 0", sdo); end
    do_reset(2'b01, 1'b1);
    begin
      logic b;
      bit_cycle(1'b0, b);
      checks++;
      if (b !== 1'b0) begin errors++; $display("FAIL R1 idle: actual %b expected 0", b); end
    end
  endtask

  task automatic t_lj24();
    do_reset(2'b01, 1'b1);
    strobe(24'hA5C3F1, 24'h3C0F96);
    frame("R2 R4 lj24");
    strobe(24'h800001, 24'h7FFFFE);
    frame("R2 R4 lj24 second");
  endtask

  task automatic t_i2s24();
    do_reset(2'b00, 1'b1);
    strobe(24'hF0F0F0, 24'h123457);
    frame("R3 R4 i2s24");
    strobe(24'h0FFFFF, 24'hC00003);
    frame("R3 R4 i2s24 second");
  endtask

  task automatic t_lj16();
    do_reset(2'b11, 1'b0);
    strobe(24'hBEEF5A, 24'h4321FF);
    frame("R5 lj16");
  endtask

  task automatic t_i2s16();
    do_reset(2'b10, 1'b0);
    strobe(24'h9ABD01, 24'h00017F);
    frame("R5 i2s16");
    strobe(24'hFFFE00, 24'h5556AA);
    frame("R5 i2s16 carry");
  endtask

  task automatic t_master16();
    do_reset(2'b11, 1'b1);
    strobe(24'hD2B4F6, 24'h1E2D3C);
    frame("R6 master ignores short");
  endtask

  task automatic t_repeat();
    do_reset(2'b01, 1'b0);
    strobe(24'h6B5A49, 24'h918273);
    frame("R8 first");
    frame("R8 repeat");
    half(1'b1, 32, "R8 midframe");
    strobe(24'h111111, 24'hEEEEEE);
    half(1'b0, 32, "R8 midframe keeps right");
    frame("R8 midframe taken");
  endtask

  task automatic t_realign();
    do_reset(2'b01, 1'b0);
    strobe(24'hC71E38, 24'hA9B8C7);
    half(1'b1, 10, "R9 short left");
    half(1'b0, 32, "R9 realigned right");
    frame("R9 after realign");
    do_reset(2'b00, 1'b0);
    strobe(24'h35AC53, 24'hE1D2C3);
    half(1'b1, 32, "R9 i2s left");
    half(1'b0, 7, "R9 i2s short right");
    frame("R9 i2s realigned");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lj24();
    t_i2s24();
    t_lj16();
    t_i2s16();
    t_master16();
    t_repeat();
    t_realign();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule